// File: doc/BRIEF.md
# Exception Syndrome Register

This block holds a 32-bit syndrome word that tells software why the last precise interrupt was taken. The core's exception logic gives the block one-cycle strobes for four event classes: program interrupts, data-storage interrupts, a combined data-TLB-miss or instruction-storage class, and instruction-side machine checks. Each strobe comes with qualifier inputs that pick which syndrome bits describe the event. The block also takes the machine-check enable bit from the machine state register and a software write port. The output is the register value, updated one clock after the event.

The instruction machine-check flag works apart from the other bits. Precise interrupts keep it as it is and rebuild every other bit. An enabled machine check wipes the program and storage bits. A disabled machine check only adds its own flag, because the interrupt is not taken and the other state must survive.

Bit numbering is big-endian: syndrome bit 0 is port bit [31], and syndrome bit k is port bit [31-k].

Top module: `esr_unit`

## Requirements
- R1: Field positions (syndrome bit / port bit): machine check 0/[31], trap 6/[25], unimplemented op 7/[24], store fault 8/[23], zone fault 9/[22], floating-point interrupt 12/[19], auxiliary-unit interrupt 13/[18], U0 fault 16/[15]. The writable mask is 32'h83CC_8000.
- R2: Every bit outside the writable mask reads zero at all times, including after a software write of all ones.
- R3: A program or data-storage strobe keeps the machine-check bit, clears every other bit, and sets only the bits its qualifiers select. Program uses trap, unimplemented, floating-point and auxiliary. Data storage uses store, zone and U0.
- R4: The store-fault bit is set by a data-storage event whose instruction is a store, or is a cache block invalidate, zero or congruence-class invalidate (cache-op qualifier).
- R5: An instruction machine check with the enable high sets the machine-check bit and clears all other bits. This also holds when a precise event strobes in the same cycle.
- R6: An instruction machine check with the enable low sets the machine-check bit and leaves all other bits unchanged.
- R7: A disabled machine check in the same cycle as a program, data-storage or TLB-miss/instruction-storage event sets the machine-check bit, and applies the other event's bits by its own rule.
- R8: A TLB-miss/instruction-storage strobe keeps the machine-check bit, clears the others, and sets the zone-fault bit only when its zone qualifier is high.
- R9: A software write with no hardware event loads the write data ANDed with the writable mask, visible the next cycle.
- R10: When a hardware event and a software write occur in the same cycle, the hardware rule decides the value and the write data is ignored.
- R11: Synchronous active-low reset clears the register to zero. Simultaneous precise strobes OR their cause bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_stb | input | 1 | Program interrupt strobe |
| prog_trap | input | 1 | Qualifier: trap compare succeeded |
| prog_unimpl | input | 1 | Qualifier: unimplemented auxiliary/floating op |
| prog_fpu | input | 1 | Qualifier: floating-point interrupt |
| prog_aux | input | 1 | Qualifier: auxiliary-unit interrupt |
| dsi_stb | input | 1 | Data-storage interrupt strobe |
| dsi_store | input | 1 | Qualifier: faulting instruction is a store |
| dsi_cacheop | input | 1 | Qualifier: faulting instruction is a cache invalidate/zero op |
| dsi_zone | input | 1 | Qualifier: zone fault |
| dsi_u0 | input | 1 | Qualifier: U0 fault |
| xlat_stb | input | 1 | Data TLB miss or instruction-storage strobe |
| xlat_zone | input | 1 | Qualifier: zone fault for that event |
| imc_stb | input | 1 | Instruction-side machine check strobe |
| mc_enable | input | 1 | Machine-check enable from the machine state |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| syn_q | output | 32 | Current syndrome value |

## Verification
The bench puts an enabled machine check right after a program interrupt. A design that kept the trap bit would leave it set. It puts a disabled machine check right after a store fault, where clearing the store bit would lose the earlier cause. It drives a disabled machine check together with a program event, and an enabled one together with a data-storage event, to catch wrong priority. It also drives a software write together with hardware events and an all-ones write, which would show write-over-hardware ordering or leaking reserved bits.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int W = 32;

  // big-endian syndrome bit numbers; behaviour depends on their positions
  localparam int B_MC     = 0;
  localparam int B_TRAP   = 6;
  localparam int B_UNIMPL = 7;
  localparam int B_STORE  = 8;
  localparam int B_ZONE   = 9;
  localparam int B_FPU    = 12;
  localparam int B_AUX    = 13;
  localparam int B_U0     = 16;

  typedef logic [W-1:0] syn_t;

  localparam syn_t M_MC     = syn_t'(1) << (W-1-B_MC);
  localparam syn_t M_TRAP   = syn_t'(1) << (W-1-B_TRAP);
  localparam syn_t M_UNIMPL = syn_t'(1) << (W-1-B_UNIMPL);
  localparam syn_t M_STORE  = syn_t'(1) << (W-1-B_STORE);
  localparam syn_t M_ZONE   = syn_t'(1) << (W-1-B_ZONE);
  localparam syn_t M_FPU    = syn_t'(1) << (W-1-B_FPU);
  localparam syn_t M_AUX    = syn_t'(1) << (W-1-B_AUX);
  localparam syn_t M_U0     = syn_t'(1) << (W-1-B_U0);

  localparam syn_t M_WRITABLE = M_MC | M_TRAP | M_UNIMPL | M_STORE |
                                M_ZONE | M_FPU | M_AUX | M_U0;
endpackage

// File: rtl/esr_cause_enc.sv
module esr_cause_enc
  import esr_pkg::*;
(
  input  logic prog_stb,
  input  logic prog_trap,
  input  logic prog_unimpl,
  input  logic prog_fpu,
  input  logic prog_aux,
  input  logic dsi_stb,
  input  logic dsi_store,
  input  logic dsi_cacheop,
  input  logic dsi_zone,
  input  logic dsi_u0,
  input  logic xlat_stb,
  input  logic xlat_zone,
  output syn_t cause,
  output logic precise
);
  syn_t prog_bits, dsi_bits, xlat_bits;

  always_comb begin
    prog_bits = '0;
    if (prog_stb) begin
      if (prog_trap)   prog_bits |= M_TRAP;
      if (prog_unimpl) prog_bits |= M_UNIMPL;
      if (prog_fpu)    prog_bits |= M_FPU;
      if (prog_aux)    prog_bits |= M_AUX;
    end
  end

  always_comb begin
    dsi_bits = '0;
    if (dsi_stb) begin
      // cache invalidate / zero operations count as stores (R4)
      if (dsi_store || dsi_cacheop) dsi_bits |= M_STORE;
      if (dsi_zone)                 dsi_bits |= M_ZONE;
      if (dsi_u0)                   dsi_bits |= M_U0;
    end
  end

  assign xlat_bits = (xlat_stb && xlat_zone) ? M_ZONE : '0;
  assign cause     = prog_bits | dsi_bits | xlat_bits;
  assign precise   = prog_stb | dsi_stb | xlat_stb;
endmodule

// File: rtl/esr_next.sv
module esr_next
  import esr_pkg::*;
(
  input  syn_t cur,
  input  syn_t cause,
  input  logic precise,
  input  logic imc_stb,
  input  logic mc_enable,
  input  logic sw_we,
  input  syn_t sw_wdata,
  output syn_t nxt,
  output logic load
);
  logic imc_taken, imc_quiet;

  assign imc_taken = imc_stb & mc_enable;
  assign imc_quiet = imc_stb & ~mc_enable;

  always_comb begin
    nxt = cur;
    if (imc_taken) begin
      nxt = M_MC;                              // R5
    end else if (precise) begin
      nxt = (cur & M_MC) | cause;              // R3, R8
      if (imc_quiet) nxt = nxt | M_MC;         // R7
    end else if (imc_quiet) begin
      nxt = cur | M_MC;                        // R6
    end else if (sw_we) begin
      nxt = sw_wdata & M_WRITABLE;             // R9
    end
  end

  assign load = imc_stb | precise | sw_we;
endmodule

// File: rtl/esr_unit.sv
module esr_unit
  import esr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_stb,
  input  logic        prog_trap,
  input  logic        prog_unimpl,
  input  logic        prog_fpu,
  input  logic        prog_aux,
  input  logic        dsi_stb,
  input  logic        dsi_store,
  input  logic        dsi_cacheop,
  input  logic        dsi_zone,
  input  logic        dsi_u0,
  input  logic        xlat_stb,
  input  logic        xlat_zone,
  input  logic        imc_stb,
  input  logic        mc_enable,
  input  logic        sw_we,
  input  logic [31:0] sw_wdata,
  output logic [31:0] syn_q
);
  syn_t cause, nxt, r_q;
  logic precise, load;

  esr_cause_enc u_enc (
    .prog_stb, .prog_trap, .prog_unimpl, .prog_fpu, .prog_aux,
    .dsi_stb, .dsi_store, .dsi_cacheop, .dsi_zone, .dsi_u0,
    .xlat_stb, .xlat_zone,
    .cause, .precise
  );

  esr_next u_next (
    .cur(r_q), .cause, .precise, .imc_stb, .mc_enable,
    .sw_we, .sw_wdata, .nxt, .load
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    r_q <= '0;               // R11
    else if (load) r_q <= nxt;
  end

  assign syn_q = r_q;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_q & ~M_WRITABLE) == '0);

  p_imc_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (imc_stb && mc_enable) |=> syn_q == M_MC);

  p_imc_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (imc_stb && !mc_enable && !prog_stb && !dsi_stb && !xlat_stb)
      |=> syn_q == ($past(syn_q) | M_MC));

  p_imc_join_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (imc_stb && (prog_stb || dsi_stb || xlat_stb)) |=> syn_q[W-1-B_MC]);

  p_keep_mc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_stb || dsi_stb) && !imc_stb)
      |=> syn_q[W-1-B_MC] == $past(syn_q[W-1-B_MC]));

  p_sw_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !imc_stb && !prog_stb && !dsi_stb && !xlat_stb)
      |=> syn_q == ($past(sw_wdata) & M_WRITABLE));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !imc_stb && !prog_stb && !dsi_stb && !xlat_stb)
      |=> $stable(syn_q));
endmodule

// File: tb/esr_unit_tb.sv
module esr_unit_tb;
  localparam logic [31:0] MC = 32'h8000_0000, TRAP = 32'h0200_0000,
    UNIMPL = 32'h0100_0000, STORE = 32'h0080_0000, ZONE = 32'h0040_0000,
    FPU = 32'h0008_0000, AUX = 32'h0004_0000, U0 = 32'h0000_8000,
    WM = 32'h83CC_8000;

  logic clk = 0, rst_n = 0;
  logic prog_stb = 0, prog_trap = 0, prog_unimpl = 0, prog_fpu = 0, prog_aux = 0;
  logic dsi_stb = 0, dsi_store = 0, dsi_cacheop = 0, dsi_zone = 0, dsi_u0 = 0;
  logic xlat_stb = 0, xlat_zone = 0, imc_stb = 0, mc_enable = 0, sw_we = 0;
  logic [31:0] sw_wdata = 0;
  logic [31:0] syn_q;

  always #10 clk = ~clk;

  esr_unit u_dut (.*);

  logic [31:0] model = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic clear_in();
    {prog_stb, prog_trap, prog_unimpl, prog_fpu, prog_aux} = '0;
    {dsi_stb, dsi_store, dsi_cacheop, dsi_zone, dsi_u0} = '0;
    {xlat_stb, xlat_zone, imc_stb, sw_we} = '0;
    sw_wdata = '0;
  endtask

  // inputs are already set; compute expectation from the requirements
  task automatic apply(string tag);
    logic [31:0] c, e;
    c = 0;
    if (prog_stb) c |= (prog_trap ? TRAP : 0) | (prog_unimpl ? UNIMPL : 0)
                     | (prog_fpu ? FPU : 0) | (prog_aux ? AUX : 0);
    if (dsi_stb)  c |= ((dsi_store || dsi_cacheop) ? STORE : 0)
                     | (dsi_zone ? ZONE : 0) | (dsi_u0 ? U0 : 0);
    if (xlat_stb && xlat_zone) c |= ZONE;
    if (imc_stb && mc_enable) e = MC;
    else if (prog_stb || dsi_stb || xlat_stb) e = (model & MC) | c | (imc_stb ? MC : 0);
    else if (imc_stb) e = model | MC;
    else if (sw_we) e = sw_wdata & WM;
    else e = model;
    model = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    clear_in();
  endtask

  // monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (syn_q !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, syn_q, e);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    sw_wdata = 32'hFFFF_FFFF; sw_we = 1;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (syn_q !== 0) begin n_bad++; $display("FAIL R11 reset: got %h expected %h", syn_q, 32'h0); end
    sw_we = 0; sw_wdata = 0;
    rst_n = 1;
    @(negedge clk);

    // R1/R3: program trap+fpu
    prog_stb = 1; prog_trap = 1; prog_fpu = 1; apply("R1 R3 prog trap+fpu");
    // R5: enabled machine check after program interrupt
    mc_enable = 1; imc_stb = 1; apply("R5 enabled mc after prog");
    // R3: program keeps MC, clears rest
    prog_stb = 1; prog_unimpl = 1; prog_aux = 1; apply("R3 prog keeps mc");
    // R3/R4: data storage store fault, MC preserved
    dsi_stb = 1; dsi_store = 1; dsi_u0 = 1; apply("R3 R4 dsi store+u0");
    // R6: disabled machine check after store fault
    mc_enable = 0; imc_stb = 1; apply("R6 disabled mc keeps store");
    // R9/R2: software write of all ones
    sw_we = 1; sw_wdata = 32'hFFFF_FFFF; apply("R9 R2 sw all ones");
    // R4: cache op counts as store
    dsi_stb = 1; dsi_cacheop = 1; apply("R4 cache op store");
    // R9 clear then R8 zone
    sw_we = 1; sw_wdata = 32'h0; apply("R9 sw clear");
    xlat_stb = 1; xlat_zone = 1; apply("R8 xlat zone");
    xlat_stb = 1; apply("R8 xlat no zone");
    // R7: disabled mc together with program event
    sw_we = 1; sw_wdata = ZONE | U0; apply("R9 sw preset");
    imc_stb = 1; prog_stb = 1; prog_trap = 1; apply("R7 disabled mc + prog");
    // R7: disabled mc with xlat
    imc_stb = 1; xlat_stb = 1; xlat_zone = 1; apply("R7 disabled mc + xlat");
    // R5: enabled mc together with dsi
    mc_enable = 1; imc_stb = 1; dsi_stb = 1; dsi_zone = 1; apply("R5 enabled mc + dsi");
    mc_enable = 0;
    // R10: hardware beats software write
    sw_we = 1; sw_wdata = 32'hFFFF_FFFF; dsi_stb = 1; dsi_zone = 1; apply("R10 hw over sw dsi");
    sw_we = 1; sw_wdata = 32'h0; imc_stb = 1; apply("R10 hw over sw imc");
    // R11: simultaneous precise strobes OR together
    prog_stb = 1; prog_trap = 1; dsi_stb = 1; dsi_store = 1; apply("R11 prog+dsi merge");
    // idle holds
    apply("R10 idle hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule